// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block listens on a single serial input line that idles high. It detects the falling edge that opens a frame and confirms the start bit at its centre. It then takes each data bit, an optional parity bit and the first stop bit at its centre. Timing comes from a programmable prescaler. The prescaler emits one sample tick every `divisor_i + 1` clocks. A bit spans 16 ticks, or 8 ticks when double-speed mode is selected.

The received character is placed right-aligned on `data_o`, with the first bit received in bit 0. It is announced by a one-cycle `valid_o` pulse. A parity-error flag and a framing-error flag accompany that pulse. The frame format must match the far-end transmitter. The format settings are:

- character length of 5 to 9 bits;
- parity off, even or odd;
- one or two stop bits.

The configuration inputs must be held stable while a frame is in flight.

Top module: `serial_rx_os`

## Requirements
- R1: While `rst_ni` is low and after its release with an idle line, `valid_o`, `parity_err_o`, `frame_err_o` and `data_o` are all 0.
- R2: One bit spans `(divisor_i+1)*16` clock cycles when `double_speed_i` is 0, and `(divisor_i+1)*8` when it is 1. A frame sent at that rate is received exactly once.
- R3: The first data bit after the start bit lands in `data_o[0]`, the next in `data_o[1]`, and so on. Bits of `data_o` at or above the character length read 0.
- R4: `data_bits_i` holds the character length as a plain binary count from 5 to 9. A value below 5 acts as 5 and a value above 9 acts as 9.
- R5: With `parity_en_i`=1, the bit after the data is the parity bit. With `parity_odd_i`=0, the data and parity bits together must hold an even number of ones; with `parity_odd_i`=1 they must hold an odd number. Otherwise `parity_err_o` is 1 with `valid_o`.
- R6: With `parity_en_i`=0, no parity bit is expected, the stop bit directly follows the data, and `parity_err_o` stays 0.
- R7: If the first stop bit reads 0 at its centre, `frame_err_o` is 1 with `valid_o`. The character is still delivered.
- R8: A low pulse that has ended before the centre of the start bit is discarded and produces no `valid_o`.
- R9: `valid_o` lasts exactly one clock. It rises near the centre of the first stop bit. The error flags are 0 whenever `valid_o` is 0.
- R10: With `two_stop_i`=1, the receiver ignores the line until the centre of the second stop bit. Frames sent back to back with two stop bits are all received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input line, idle high |
| divisor_i | input | DIV_W | Prescaler value; tick every divisor_i+1 clocks |
| double_speed_i | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| data_bits_i | input | 4 | Character length, 5 to 9 |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1: odd parity, 0: even parity |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| data_o | output | DATA_W | Received character, right-aligned |
| valid_o | output | 1 | One-cycle pulse with a new character |
| parity_err_o | output | 1 | Parity mismatch, valid with valid_o |
| frame_err_o | output | 1 | First stop bit read low, valid with valid_o |

## Verification
A wrong bit counter or sample-tick counter shows up within the affected frame. It appears as a missing or duplicated `valid_o`, or as a shifted or truncated `data_o`, by the centre of that frame's stop bit. A wrong parity or framing decision is visible on the same pulse as the character. A wrong start-check or idle-edge state shows as a spurious character after a glitch, or as a lost frame in a back-to-back sequence, one frame time later. The bench therefore sweeps every length, parity mode, stop count and speed, and compares each pulse against an arithmetic model.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= divisor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              double_speed_i,
  input  logic [3:0]        data_bits_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [3:0]        sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              prev_q, par_q;
  logic [3:0]        last_tick, mid_tick, nbits;
  logic [IDX_W-1:0]  last_idx;
  logic              exp_par, at_end;

  always_comb begin
    last_tick = double_speed_i ? 4'd7 : 4'd15;
    mid_tick  = double_speed_i ? 4'd3 : 4'd7;
    if (data_bits_i < 4'd5)      nbits = 4'd5;
    else if (data_bits_i > 4'd9) nbits = 4'd9;
    else                         nbits = data_bits_i;
    last_idx = IDX_W'(nbits - 4'd1);
    exp_par  = (^shift_q) ^ parity_odd_i;
    at_end   = (sub_q == last_tick);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sub_q        <= '0;
      idx_q        <= '0;
      shift_q      <= '0;
      prev_q       <= 1'b1;
      par_q        <= 1'b0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      parity_err_o <= 1'b0;
      frame_err_o  <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            prev_q <= line_i;
            sub_q  <= '0;
            if (prev_q && !line_i) state_q <= ST_START;
          end
          ST_START: begin
            if (sub_q == mid_tick) begin
              sub_q <= '0;
              if (line_i) begin
                state_q <= ST_IDLE;   // glitch
                prev_q  <= 1'b1;
              end else begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                shift_q <= '0;
              end
            end else sub_q <= sub_q + 1'b1;
          end
          ST_DATA: begin
            if (at_end) begin
              sub_q          <= '0;
              shift_q[idx_q] <= line_i;
              idx_q          <= idx_q + 1'b1;
              if (idx_q == last_idx) state_q <= parity_en_i ? ST_PARITY : ST_STOP1;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_PARITY: begin
            if (at_end) begin
              sub_q   <= '0;
              par_q   <= line_i;
              state_q <= ST_STOP1;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_STOP1: begin
            if (at_end) begin
              sub_q        <= '0;
              data_o       <= shift_q;
              valid_o      <= 1'b1;
              frame_err_o  <= !line_i;
              parity_err_o <= parity_en_i && (par_q != exp_par);
              prev_q       <= line_i;
              state_q      <= two_stop_i ? ST_STOP2 : ST_IDLE;
            end else sub_q <= sub_q + 1'b1;
          end
          ST_STOP2: begin
            if (at_end) begin
              sub_q   <= '0;
              prev_q  <= line_i;
              state_q <= ST_IDLE;
            end else sub_q <= sub_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_os.sv
module serial_rx_os #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  divisor_i,
  input  logic              double_speed_i,
  input  logic [3:0]        data_bits_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              two_stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              parity_err_o,
  output logic              frame_err_o
);
  logic line_s, tick_s;

  serial_rx_sync #(.RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (line_s)
  );

  serial_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .divisor_i(divisor_i),
    .tick_o   (tick_s)
  );

  serial_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_s),
    .line_i        (line_s),
    .double_speed_i(double_speed_i),
    .data_bits_i   (data_bits_i),
    .parity_en_i   (parity_en_i),
    .parity_odd_i  (parity_odd_i),
    .two_stop_i    (two_stop_i),
    .data_o        (data_o),
    .valid_o       (valid_o),
    .parity_err_o  (parity_err_o),
    .frame_err_o   (frame_err_o)
  );
endmodule

// File: rtl/serial_rx_os_checker.sv
module serial_rx_os_checker #(
  parameter int DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        data_bits_i,
  input logic              parity_en_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              parity_err_o,
  input logic              frame_err_o
);
  a_r9_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_flags_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o || frame_err_o) |-> valid_o);

  a_r6_no_parity_err_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !parity_en_i) |-> !parity_err_o);

  a_r3_upper_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && data_bits_i >= 4'd5 && data_bits_i <= 4'd9)
      |-> ((data_o >> data_bits_i) == '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !valid_o);
endmodule

bind serial_rx_os serial_rx_os_checker #(.DATA_W(DATA_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_bits_i (data_bits_i),
  .parity_en_i (parity_en_i),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .parity_err_o(parity_err_o),
  .frame_err_o (frame_err_o)
);

// File: tb/serial_rx_os_test.sv
`timescale 1ns/1ps
module serial_rx_os_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic [11:0] divisor = 12'd1;
  logic        dbl = 1'b0;
  logic [3:0]  nbits = 4'd8;
  logic        par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic [8:0]  data_o;
  logic        valid_o, parity_err_o, frame_err_o;

  int compared = 0, mismatched = 0;
  int got_cnt = 0, long_pulse = 0, stray_flag = 0;
  logic [8:0] got_data;
  logic got_pe, got_fe, prev_valid = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_rx_os uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .divisor_i(divisor),
    .double_speed_i(dbl), .data_bits_i(nbits), .parity_en_i(par_en),
    .parity_odd_i(par_odd), .two_stop_i(two_stop), .data_o(data_o),
    .valid_o(valid_o), .parity_err_o(parity_err_o), .frame_err_o(frame_err_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      got_cnt++;
      got_data = data_o;
      got_pe = parity_err_o;
      got_fe = frame_err_o;
      if (prev_valid) long_pulse++;
    end else if (parity_err_o || frame_err_o) stray_flag++;
    prev_valid = valid_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (int'(divisor) + 1) * (dbl ? 8 : 16);
  endfunction

  task automatic drive_bits(input logic v, input int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(input logic [8:0] v, input int nb, input int pm, input bit st2,
                      input bit bad_par, input bit bad_stop, input int idle_bits);
    int t;
    logic [8:0] m;
    logic p;
    t = bit_clks();
    m = 9'((1 << nb) - 1);
    p = ^(v & m);
    if (pm == 2) p = ~p;
    if (bad_par) p = ~p;
    drive_bits(1'b0, t);
    for (int i = 0; i < nb; i++) drive_bits(v[i], t);
    if (pm != 0) drive_bits(p, t);
    drive_bits(!bad_stop, t);
    if (st2) drive_bits(1'b1, t);
    drive_bits(1'b1, t * idle_bits);
  endtask

  task automatic frame_test(input logic [8:0] v, input int nb, input int pm, input bit st2,
                            input bit bad_par, input bit bad_stop, input string tag);
    int base;
    logic [8:0] m;
    m = 9'((1 << nb) - 1);
    nbits = 4'(nb); par_en = (pm != 0); par_odd = (pm == 2); two_stop = st2;
    base = got_cnt;
    send(v, nb, pm, st2, bad_par, bad_stop, 1);
    check(got_cnt - base == 1, {tag, " R2 count"}, got_cnt - base, 1);
    check(got_data == (v & m), {tag, " R3 data"}, int'(got_data), int'(v & m));
    check(got_pe == (bad_par && pm != 0), {tag, " R5 R6 parity_err"}, int'(got_pe),
          int'(bad_par && pm != 0));
    check(got_fe == bad_stop, {tag, " R7 frame_err"}, int'(got_fe), int'(bad_stop));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(!valid_o && !parity_err_o && !frame_err_o && data_o == 0, "R1 in reset",
          int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(got_cnt == 0 && data_o == 0, "R1 idle after reset", got_cnt, 0);

    // R2 R4 R5 R6 R10: sweep every format at both speeds
    for (int spd = 0; spd < 2; spd++) begin
      dbl = spd[0];
      divisor = spd ? 12'd2 : 12'd1;
      for (int nb = 5; nb <= 9; nb++)
        for (int pm = 0; pm < 3; pm++)
          for (int st = 0; st < 2; st++)
            for (int k = 0; k < 3; k++)
              frame_test(9'((nb * 37 + pm * 11 + st * 5 + k * 91) ^ (k == 2 ? 9'h1FF : 9'h0)),
                         nb, pm, st[0], 1'b0, 1'b0, "R4 sweep");
    end

    // R3: every 5-bit character, fastest rate
    divisor = 12'd0; dbl = 1'b1;
    for (int v = 0; v < 32; v++) frame_test(9'(v), 5, 1, 1'b0, 1'b0, 1'b0, "R3 exhaustive");

    // R5 parity errors, R7 framing errors
    divisor = 12'd1; dbl = 1'b0;
    frame_test(9'h0A5, 8, 1, 1'b0, 1'b1, 1'b0, "R5 bad even");
    frame_test(9'h13C, 9, 2, 1'b1, 1'b1, 1'b0, "R5 bad odd");
    frame_test(9'h055, 7, 0, 1'b0, 1'b0, 1'b1, "R7 bad stop");
    frame_test(9'h0F0, 8, 2, 1'b0, 1'b1, 1'b1, "R7 both errors");

    // R8: short glitch
    base = got_cnt;
    drive_bits(1'b0, bit_clks() / 4);
    drive_bits(1'b1, bit_clks() * 14);
    check(got_cnt == base, "R8 glitch rejected", got_cnt - base, 0);
    frame_test(9'h03C, 8, 0, 1'b0, 1'b0, 1'b0, "R8 after glitch");

    // R10: back-to-back two-stop frames
    nbits = 4'd8; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    base = got_cnt;
    send(9'h0C3, 8, 1, 1'b1, 1'b0, 1'b0, 0);
    check(got_data == 9'h0C3 && !got_pe && !got_fe, "R10 b2b first", int'(got_data), 'hC3);
    send(9'h01E, 8, 1, 1'b1, 1'b0, 1'b0, 0);
    send(9'h0FF, 8, 1, 1'b1, 1'b0, 1'b0, 2);
    check(got_cnt - base == 3, "R10 b2b count", got_cnt - base, 3);
    check(got_data == 9'h0FF && !got_pe && !got_fe, "R10 b2b last", int'(got_data), 'hFF);

    check(long_pulse == 0, "R9 valid one cycle", long_pulse, 0);
    check(stray_flag == 0, "R9 flags only with valid", stray_flag, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule